// File: doc/BRIEF.md
# Reloading Down-Counter Interval Timer

This block is an interval timer built around a down-counter with a programmable reload latch. A narrow write bus fills the latch one half at a time and sets a control register that starts and stops the timer, picks one-shot or continuous operation, selects the count source and issues a force-load strobe. Count events come from the system clock or from an external enable input. Either way they pass through a single pipeline register before they reach the counter.

When a pending count event finds the counter at one, the counter reloads from the latch instead of reaching zero. It pulses an underflow output for one clock and sets a sticky interrupt flag. The reload also drops the event being captured on that edge. As a result the counter never shows zero and the reload value is seen for two cycles. A force-load copies the latch into the counter one clock after the control write. It leaves the count pipeline alone, so an underflow that is already on its way still happens and still raises the interrupt.

Top module: `reload_timer`

## Requirements
- R1: After reset the counter reads 16'hFFFF, the latch holds 16'hFFFF, the control readback is 0, and the underflow output and interrupt flag are 0.
- R2: Write addresses are 0 for the latch low byte, 1 for the latch high byte and 2 for control. A high-byte write while the timer is stopped loads {new high byte, latch low byte} into the counter on the same edge. A high-byte write while the timer runs leaves the counter unchanged.
- R3: An event sampled on a clock edge decrements the counter on the following edge. With the system clock as source and a latch value L, the counter shows L on the first edge after start and L-1 on the second.
- R4: A pending event that finds the counter at 1 reloads it from the latch and discards the event sampled on that same edge. The visible sequence for L=4 is 4,3,2,1,4,4,3,2, and zero never appears.
- R5: Every reload caused by an underflow drives the underflow output high for exactly one clock and sets the interrupt flag. The flag stays set until irq_ack is high on a clock edge.
- R6: With control bit 1 (one-shot) set, an underflow clears the start bit (control bit 0) and the counter then holds the reload value. With bit 1 clear, counting continues from the reload value.
- R7: With control bit 2 set, each clock edge on which ext_cnt is high produces exactly one decrement, on the next edge. With bit 2 clear, every clock counts.
- R8: Control bit 4 (force-load) loads the latch into the counter on the second edge after the write. The counter is unchanged on the write edge, and the count pipeline is not cleared.
- R9: If a force-load takes effect on the same edge as an underflow reload, the counter takes the latch value once, and the underflow pulse and interrupt flag still occur.
- R10: Control readback returns start in bit 0, one-shot in bit 1 and source in bit 2. Bit 4 and all other bits always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write address: 0 latch low, 1 latch high, 2 control |
| wr_data | input | 8 | Write data |
| ext_cnt | input | 1 | External count enable |
| irq_ack | input | 1 | Clears the interrupt flag |
| cnt_out | output | 16 | Live counter value |
| ctrl_rd | output | 8 | Control register readback |
| underflow | output | 1 | One-clock pulse per underflow reload |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The bench builds the timer with its default 16-bit counter and 8-bit bus. With these values, small latch values make a full reload period only a few cycles long. The bench sweeps every latch value from 1 to 12 in continuous system-clock mode and compares each cycle against a closed-form expected value, so the repeated reload value and the underflow pulses are checked across several periods. It also uses external-count pulses to place a force-load exactly one cycle before an underflow.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_HI   = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  localparam int CB_START   = 0;
  localparam int CB_ONESHOT = 1;
  localparam int CB_SRC     = 2;
  localparam int CB_FORCE   = 4;

  typedef struct packed {
    logic src;
    logic oneshot;
    logic start;
  } ctrl_t;
endpackage

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int BUS_W = CNT_W / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             uf_evt,
  output logic [CNT_W-1:0] latch_q,
  output ctrl_t            ctrl_q,
  output logic             force_q,
  output logic             hi_load,
  output logic [CNT_W-1:0] load_val
);
  logic  wr_lo, wr_hi, wr_ctrl;
  ctrl_t ctrl_nxt;

  assign wr_lo   = wr_en && (wr_sel == SEL_LO);
  assign wr_hi   = wr_en && (wr_sel == SEL_HI);
  assign wr_ctrl = wr_en && (wr_sel == SEL_CTRL);

  // high write while stopped copies the fresh latch straight into the counter
  assign hi_load  = wr_hi && !ctrl_q.start;
  assign load_val = {wr_data, latch_q[BUS_W-1:0]};

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (wr_ctrl) begin
      ctrl_nxt.start   = wr_data[CB_START];
      ctrl_nxt.oneshot = wr_data[CB_ONESHOT];
      ctrl_nxt.src     = wr_data[CB_SRC];
    end
    if (uf_evt && ctrl_nxt.oneshot) ctrl_nxt.start = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '1;
      ctrl_q  <= '0;
      force_q <= 1'b0;
    end else begin
      if (wr_lo) latch_q[BUS_W-1:0]     <= wr_data;
      if (wr_hi) latch_q[CNT_W-1:BUS_W] <= wr_data;
      ctrl_q  <= ctrl_nxt;
      force_q <= wr_ctrl && wr_data[CB_FORCE];
    end
  end
endmodule

// File: rtl/timer_pipe.sv
module timer_pipe (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic src_ext,
  input  logic ext_cnt,
  input  logic drop,
  output logic pend
);
  logic evt;

  assign evt = run && (src_ext ? ext_cnt : 1'b1);

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= drop ? 1'b0 : evt;
  end
endmodule

// File: rtl/timer_core.sv
module timer_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pend,
  input  logic             force_q,
  input  logic             hi_load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] latch_q,
  input  logic             irq_ack,
  output logic             uf_evt,
  output logic [CNT_W-1:0] cnt_q,
  output logic             uf_q,
  output logic             irq_q
);
  assign uf_evt = pend && (cnt_q[CNT_W-1:1] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '1;
      uf_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (force_q || uf_evt) cnt_q <= latch_q;
      else if (hi_load)      cnt_q <= load_val;
      else if (pend)         cnt_q <= cnt_q - 1'b1;
      uf_q <= uf_evt;
      if (uf_evt)       irq_q <= 1'b1;
      else if (irq_ack) irq_q <= 1'b0;
    end
  end
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import timer_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int BUS_W = CNT_W / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             ext_cnt,
  input  logic             irq_ack,
  output logic [CNT_W-1:0] cnt_out,
  output logic [BUS_W-1:0] ctrl_rd,
  output logic             underflow,
  output logic             irq_flag
);
  logic [CNT_W-1:0] latch_q, load_val;
  ctrl_t            ctrl_q;
  logic             force_q, hi_load, uf_evt, pend;
  logic             run_w, oneshot_w;

  assign run_w     = ctrl_q.start;
  assign oneshot_w = ctrl_q.oneshot;

  timer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .uf_evt(uf_evt), .latch_q(latch_q), .ctrl_q(ctrl_q), .force_q(force_q),
    .hi_load(hi_load), .load_val(load_val)
  );

  timer_pipe u_pipe (
    .clk(clk), .rst(rst), .run(ctrl_q.start), .src_ext(ctrl_q.src),
    .ext_cnt(ext_cnt), .drop(uf_evt), .pend(pend)
  );

  timer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .pend(pend), .force_q(force_q), .hi_load(hi_load),
    .load_val(load_val), .latch_q(latch_q), .irq_ack(irq_ack),
    .uf_evt(uf_evt), .cnt_q(cnt_out), .uf_q(underflow), .irq_q(irq_flag)
  );

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CB_START]   = ctrl_q.start;
    ctrl_rd[CB_ONESHOT] = ctrl_q.oneshot;
    ctrl_rd[CB_SRC]     = ctrl_q.src;
  end
endmodule

// File: rtl/timer_chk.sv
module timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             pend,
  input logic             force_q,
  input logic             run_w,
  input logic             oneshot_w,
  input logic [CNT_W-1:0] latch_q,
  input logic [CNT_W-1:0] cnt_out,
  input logic             underflow,
  input logic             irq_flag,
  input logic             irq_ack
);
  p_reload_r4: assert property (@(posedge clk) disable iff (rst)
    (pend && cnt_out[CNT_W-1:1] == '0) |=> (underflow && cnt_out == $past(latch_q)));

  p_drop_evt_r4: assert property (@(posedge clk) disable iff (rst)
    underflow |-> !pend);

  p_one_clock_r5: assert property (@(posedge clk) disable iff (rst)
    underflow |=> !underflow);

  p_flag_set_r5: assert property (@(posedge clk) disable iff (rst)
    underflow |-> irq_flag);

  p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !irq_ack) |=> irq_flag);

  p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (rst)
    (underflow && oneshot_w) |-> !run_w);

  p_force_load_r8: assert property (@(posedge clk) disable iff (rst)
    force_q |=> cnt_out == $past(latch_q));
endmodule

bind reload_timer timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .pend(pend), .force_q(force_q), .run_w(run_w),
  .oneshot_w(oneshot_w), .latch_q(latch_q), .cnt_out(cnt_out),
  .underflow(underflow), .irq_flag(irq_flag), .irq_ack(irq_ack)
);

// File: tb/sim_reload_timer.sv
module sim_reload_timer;
  localparam int CLK_P = 10;
  localparam int CW = 16;
  localparam int BW = CW / 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = 2'd0;
  logic [BW-1:0] wr_data = '0;
  logic          ext_cnt = 1'b0;
  logic          irq_ack = 1'b0;
  logic [CW-1:0] cnt_out;
  logic [BW-1:0] ctrl_rd;
  logic          underflow, irq_flag;
  int vecs = 0;
  int errs = 0;

  always #(CLK_P/2) clk = ~clk;

  reload_timer #(.CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ext_cnt(ext_cnt), .irq_ack(irq_ack), .cnt_out(cnt_out), .ctrl_rd(ctrl_rd),
    .underflow(underflow), .irq_flag(irq_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [BW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic ext_pulse();
    @(negedge clk); ext_cnt = 1'b1;
    @(negedge clk); ext_cnt = 1'b0;
  endtask

  task automatic stop_load(input int l);
    wr(2'd2, 8'h00);
    wr(2'd0, l[BW-1:0]);
    wr(2'd1, l[CW-1:BW]);
    ack();
  endtask

  initial begin
    #(CLK_P * 200000);
    errs++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cnt", cnt_out, 32'hFFFF);
    chk("R1 ctrl", ctrl_rd, 0);
    chk("R1 irq", irq_flag, 0);
    chk("R1 uf", underflow, 0);
    // R1/R2: stopped high write loads {hi, latch lo reset FF}
    wr(2'd1, 8'h12);
    chk("R1 R2 stopped hi load", cnt_out, 32'h12FF);

    // R3 R4 R5: continuous system-clock sweep
    for (int l = 1; l <= 12; l++) begin
      stop_load(l);
      chk("R2 load", cnt_out, l);
      chk("R5 ack clears", irq_flag, 0);
      wr(2'd2, 8'h01);
      for (int j = 1; j <= 3 * (l + 1) + 2; j++) begin
        int m;
        int ev;
        int eu;
        @(negedge clk);
        m  = (j - 2) % (l + 1);
        ev = (j == 1) ? l : ((m <= l - 2) ? (l - 1 - m) : l);
        eu = (j >= 2 && m == l - 1) ? 1 : 0;
        chk("R3 R4 count sequence", cnt_out, ev);
        chk("R5 underflow pulse", underflow, eu);
      end
      chk("R5 irq sticky", irq_flag, 1);
    end

    // R6 one-shot
    stop_load(3);
    wr(2'd2, 8'h03);
    repeat (10) @(negedge clk);
    chk("R6 oneshot holds reload", cnt_out, 3);
    chk("R6 start cleared", ctrl_rd, 8'h02);
    chk("R6 irq", irq_flag, 1);

    // R7 R9: external source, force-load one cycle before underflow
    stop_load(5);
    wr(2'd2, 8'h05);
    repeat (3) @(negedge clk);
    chk("R7 no ext no count", cnt_out, 5);
    for (int p = 0; p < 4; p++) ext_pulse();
    @(negedge clk);
    chk("R7 four ext pulses", cnt_out, 1);
    @(negedge clk);
    ext_cnt = 1'b1; wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'h15;
    @(negedge clk);
    ext_cnt = 1'b0; wr_en = 1'b0;
    chk("R8 not yet loaded", cnt_out, 1);
    chk("R10 force reads 0", ctrl_rd, 8'h05);
    @(negedge clk);
    chk("R9 reload value", cnt_out, 5);
    chk("R9 underflow", underflow, 1);
    chk("R9 irq", irq_flag, 1);
    @(negedge clk);
    chk("R9 single pulse", underflow, 0);
    chk("R9 loaded once", cnt_out, 5);

    // R2 running hi write ignored; R8 plain force-load timing
    wr(2'd0, 8'h09);
    wr(2'd1, 8'h00);
    chk("R2 running hi write ignored", cnt_out, 5);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'h15;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8 unchanged on write edge", cnt_out, 5);
    @(negedge clk);
    chk("R8 force loaded", cnt_out, 9);
    chk("R10 readback", ctrl_rd, 8'h05);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule